// File: doc/BRIEF.md
# Dual-Lane Block FIR Multiply-Accumulate Datapath

This block computes two neighbouring outputs of a finite impulse response filter at the same time, using two multiply-accumulate lanes driven by one stream. In every accepted beat it takes one signed 16-bit coefficient and one signed 16-bit sample. The coefficient goes to both lanes. The sample goes straight into lane 1. It also enters a one-beat holding register that feeds lane 0. Lane 0 therefore always works one sample behind lane 1. Each fetched coefficient and each fetched sample is used for two products. The caller does not need a second memory port.

A job begins with a start pulse that carries the tap count and the readout mode. The first valid beat after the start only loads the holding register. The next tap-count valid beats are the taps. The lane-0 result and then the lane-1 result come out on a shared result port, one cycle apart. Each is saturated on readout from its 40-bit accumulator, either to the signed 32-bit range or to a rounded signed 16-bit value. Fetching the memory, generating addresses and sequencing the work belong to the surrounding logic.

The controller is a state machine with six states:
- IDLE waits for a start.
- PRIME waits for the priming beat.
- TAPS counts the taps.
- FLUSH lets the last product reach the accumulator.
- EMIT_A presents lane 0.
- EMIT_B presents lane 1.

Its transitions are:
- IDLE to PRIME on a start with a nonzero count.
- PRIME to TAPS on a valid beat.
- TAPS to FLUSH on the valid beat that is the last tap.
- FLUSH to EMIT_A unconditionally.
- EMIT_A to EMIT_B unconditionally.
- EMIT_B to IDLE unconditionally.

In every other case the state holds.

Top module: `dual_mac_fir`

## Requirements
- R1: After reset, res_valid_o is 0 and res_o is 0.
- R2: The first valid beat after an accepted start only loads the holding register. Its coefficient contributes to neither result.
- R3: With priming sample s0, and taps k = 0..T-1 carrying coefficient c[k] and sample s[k+1], lane 0 yields the sum of c[k]*s[k] and lane 1 yields the sum of c[k]*s[k+1].
- R4: A beat with in_valid_i low is ignored in every state, including bubbles between taps.
- R5: The clock edge that samples the last tap is edge E. At edge E+2, res_valid_o is high with res_lane_o = 0 and the lane-0 result. At edge E+3, res_valid_o is high with res_lane_o = 1 and the lane-1 result. In all other cycles res_valid_o is low.
- R6: With mode 0 latched, res_o is the 40-bit sum clamped to [-2^31, 2^31-1].
- R7: With mode 1 latched, res_o is floor((sum + 2^15) / 2^16), clamped to [-32768, 32767] and sign-extended to 32 bits.
- R8: A start is ignored while a job is in progress. A start with tap_count_i = 0 is also ignored, and the block stays idle.
- R9: Each job accumulates from zero, so no sum carries over from the previous job.
- R10: sat_mode_i is sampled only with an accepted start. Changes after that do not affect the job's results.
- R11: Sums of up to 255 full-scale products are kept exactly in 40 bits before readout, with no wrap at 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for a job |
| tap_count_i | input | 8 | Number of taps, sampled with start |
| sat_mode_i | input | 1 | Readout mode: 0 = 32-bit clamp, 1 = rounded 16-bit; sampled with start |
| in_valid_i | input | 1 | Coefficient and sample are valid this cycle |
| coef_i | input | 16 | Signed coefficient, shared by both lanes |
| samp_i | input | 16 | Signed input sample |
| res_valid_o | output | 1 | Result valid pulse |
| res_lane_o | output | 1 | Lane of the current result (0 then 1) |
| res_o | output | 32 | Saturated result |

## Verification
The multiplier register and the accumulator register lie between the last tap and the readout, so the lane-0 result is due two edges after the edge that takes the last tap, and lane 1 one edge after that. The bench counts clock edges. When it drives the last tap it schedules both results for those exact edges in a queue. At every falling edge it compares the valid, lane and result outputs against the queue head, and it requires valid to be low whenever no result is due. Bubbles, ignored starts, zero-count starts and mode changes after the start therefore show up as wrong or missing pulses on the exact cycle.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRIME,
        ST_TAPS,
        ST_FLUSH,
        ST_EMIT_A,
        ST_EMIT_B
    } dmf_state_e;

    typedef enum logic {
        SAT_W32 = 1'b0,
        SAT_R16 = 1'b1
    } dmf_sat_e;
endpackage

// File: rtl/dmf_ctrl.sv
module dmf_ctrl
    import dmf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [CNT_W-1:0] tap_count_i,
    input  logic             sat_mode_i,
    input  logic             in_valid_i,
    output dmf_state_e       state_o,
    output logic             load_dly_o,
    output logic             tap_fire_o,
    output logic             tap_first_o,
    output dmf_sat_e         mode_o
);
    dmf_state_e       state_q, state_d;
    logic [CNT_W-1:0] left_q;
    logic             first_q;
    dmf_sat_e         mode_q;
    logic             accept;

    assign accept = (state_q == ST_IDLE) && start_i && (tap_count_i != '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_PRIME;
            ST_PRIME:  if (in_valid_i) state_d = ST_TAPS;
            ST_TAPS:   if (in_valid_i && left_q == CNT_W'(1)) state_d = ST_FLUSH;
            ST_FLUSH:  state_d = ST_EMIT_A;
            ST_EMIT_A: state_d = ST_EMIT_B;
            ST_EMIT_B: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_dly_o  = in_valid_i && (state_q == ST_PRIME || state_q == ST_TAPS);
        tap_fire_o  = in_valid_i && (state_q == ST_TAPS);
        tap_first_o = tap_fire_o && first_q;
        state_o     = state_q;
        mode_o      = mode_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            left_q  <= '0;
            first_q <= 1'b0;
            mode_q  <= SAT_W32;
        end else if (accept) begin
            left_q  <= tap_count_i;
            first_q <= 1'b1;
            mode_q  <= dmf_sat_e'(sat_mode_i);
        end else if (tap_fire_o) begin
            left_q  <= left_q - CNT_W'(1);
            first_q <= 1'b0;
        end
    end

    // R8: a start during a running job leaves count and mode untouched
    a_r8_busy_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && (state_q == ST_FLUSH || state_q == ST_EMIT_A || state_q == ST_EMIT_B))
        |=> ($stable(left_q) && $stable(mode_q)));

    // R8: zero tap count keeps the controller idle
    a_r8_zero_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_IDLE && start_i && tap_count_i == '0) |=> (state_q == ST_IDLE));

    // R2: the priming beat leads into the tap phase with the first-tap flag set
    a_r2_prime_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_PRIME && in_valid_i) |=> (state_q == ST_TAPS && first_q));

    // R4: a bubble changes neither state nor remaining count
    a_r4_bubble: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state_q == ST_PRIME || state_q == ST_TAPS) && !in_valid_i)
        |=> ($stable(state_q) && $stable(left_q)));
endmodule

// File: rtl/dmf_lane.sv
module dmf_lane #(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 fire_i,
    input  logic                 first_i,
    input  logic signed [DW-1:0] coef_i,
    input  logic signed [DW-1:0] samp_i,
    output logic signed [AW-1:0] acc_o
);
    localparam int PW = 2 * DW;

    logic signed [PW-1:0] prod_q;
    logic                 vld_q;
    logic                 clr_q;
    logic signed [AW-1:0] acc_q;
    logic signed [AW-1:0] prod_ext;
    logic signed [AW-1:0] acc_base;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prod_q <= '0;
            vld_q  <= 1'b0;
            clr_q  <= 1'b0;
        end else begin
            vld_q <= fire_i;
            if (fire_i) begin
                prod_q <= coef_i * samp_i;
                clr_q  <= first_i;
            end
        end
    end

    always_comb begin
        prod_ext = {{(AW-PW){prod_q[PW-1]}}, prod_q};
        acc_base = clr_q ? '0 : acc_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    acc_q <= '0;
        else if (vld_q) acc_q <= acc_base + prod_ext;
    end

    assign acc_o = acc_q;

    // R3: every accepted tap produces a product one cycle later
    a_r3_prod_pipe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire_i |=> vld_q);

    // R4: without a product in flight the accumulator holds
    a_r4_acc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vld_q |=> $stable(acc_q));
endmodule

// File: rtl/dmf_sat.sv
module dmf_sat #(
    parameter int AW = 40,
    parameter int OW = 32,
    parameter int HW = 16
) (
    input  logic signed [AW-1:0] acc_i,
    input  logic                 mode_i,
    output logic        [OW-1:0] res_o
);
    localparam int RW = AW + 1;
    localparam logic signed [AW-1:0] W_MAX = {{(AW-OW+1){1'b0}}, {(OW-1){1'b1}}};
    localparam logic signed [AW-1:0] W_MIN = {{(AW-OW+1){1'b1}}, {(OW-1){1'b0}}};
    localparam logic signed [RW-1:0] H_MAX = {{(RW-HW+1){1'b0}}, {(HW-1){1'b1}}};
    localparam logic signed [RW-1:0] H_MIN = {{(RW-HW+1){1'b1}}, {(HW-1){1'b0}}};
    localparam logic signed [RW-1:0] HALF  = RW'(1) <<< (HW-1);

    logic signed [RW-1:0] rnd;
    logic signed [RW-1:0] shf;
    logic        [HW-1:0] h_val;

    always_comb begin
        rnd = {acc_i[AW-1], acc_i} + HALF;
        shf = rnd >>> HW;
        if (shf > H_MAX)      h_val = H_MAX[HW-1:0];
        else if (shf < H_MIN) h_val = H_MIN[HW-1:0];
        else                  h_val = shf[HW-1:0];

        if (mode_i) begin
            res_o = {{(OW-HW){h_val[HW-1]}}, h_val};
        end else if (acc_i > W_MAX) begin
            res_o = W_MAX[OW-1:0];
        end else if (acc_i < W_MIN) begin
            res_o = W_MIN[OW-1:0];
        end else begin
            res_o = acc_i[OW-1:0];
        end
    end
endmodule

// File: rtl/dual_mac_fir.sv
module dual_mac_fir
    import dmf_pkg::*;
#(
    parameter int DW    = 16,
    parameter int AW    = 40,
    parameter int OW    = 32,
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [CNT_W-1:0] tap_count_i,
    input  logic             sat_mode_i,
    input  logic             in_valid_i,
    input  logic [DW-1:0]    coef_i,
    input  logic [DW-1:0]    samp_i,
    output logic             res_valid_o,
    output logic             res_lane_o,
    output logic [OW-1:0]    res_o
);
    localparam int NLANE = 2;
    localparam int HW    = DW;

    dmf_state_e           state;
    logic                 load_dly;
    logic                 tap_fire;
    logic                 tap_first;
    dmf_sat_e             mode_q;
    logic signed [DW-1:0] dly_q;
    logic signed [AW-1:0] acc [NLANE];
    logic signed [AW-1:0] sat_in;
    logic        [OW-1:0] sat_out;

    dmf_ctrl #(.CNT_W(CNT_W)) ctrl_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (start_i),
        .tap_count_i (tap_count_i),
        .sat_mode_i  (sat_mode_i),
        .in_valid_i  (in_valid_i),
        .state_o     (state),
        .load_dly_o  (load_dly),
        .tap_fire_o  (tap_fire),
        .tap_first_o (tap_first),
        .mode_o      (mode_q)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       dly_q <= '0;
        else if (load_dly) dly_q <= $signed(samp_i);
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic signed [DW-1:0] lane_samp;
        if (g == 0) begin : g_delayed
            assign lane_samp = dly_q;
        end else begin : g_direct
            assign lane_samp = $signed(samp_i);
        end
        dmf_lane #(.DW(DW), .AW(AW)) lane_i (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .fire_i  (tap_fire),
            .first_i (tap_first),
            .coef_i  ($signed(coef_i)),
            .samp_i  (lane_samp),
            .acc_o   (acc[g])
        );
    end

    assign sat_in = (state == ST_EMIT_B) ? acc[1] : acc[0];

    dmf_sat #(.AW(AW), .OW(OW), .HW(HW)) sat_i (
        .acc_i  (sat_in),
        .mode_i (mode_q == SAT_R16),
        .res_o  (sat_out)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_valid_o <= 1'b0;
            res_lane_o  <= 1'b0;
            res_o       <= '0;
        end else if (state == ST_EMIT_A || state == ST_EMIT_B) begin
            res_valid_o <= 1'b1;
            res_lane_o  <= (state == ST_EMIT_B);
            res_o       <= sat_out;
        end else begin
            res_valid_o <= 1'b0;
        end
    end

    // R5: lane 0 result is followed directly by lane 1 result
    a_r5_pair_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (res_valid_o && !res_lane_o) |=> (res_valid_o && res_lane_o));

    // R5: the lane 1 result ends the burst
    a_r5_burst_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (res_valid_o && res_lane_o) |=> !res_valid_o);

    // R7: in rounded mode the result is a sign-extended 16-bit value
    a_r7_r16_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (res_valid_o && mode_q == SAT_R16)
        |-> (res_o[OW-1:HW-1] == '0 || res_o[OW-1:HW-1] == '1));
endmodule

// File: tb/dual_mac_fir_tb_top.sv
`timescale 1ns/1ps
module dual_mac_fir_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  tap_count = '0;
    logic        sat_mode = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] coef = '0;
    logic [15:0] samp = '0;
    logic        res_valid;
    logic        res_lane;
    logic [31:0] res;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit running = 1'b0;
    bit done = 1'b0;

    int    q_cyc[$];
    bit    q_lane[$];
    int    q_val[$];
    string q_tag[$];

    int c_a[256];
    int s_a[257];

    always #2 clk = ~clk;

    dual_mac_fir dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .start_i     (start),
        .tap_count_i (tap_count),
        .sat_mode_i  (sat_mode),
        .in_valid_i  (in_valid),
        .coef_i      (coef),
        .samp_i      (samp),
        .res_valid_o (res_valid),
        .res_lane_o  (res_lane),
        .res_o       (res)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int ref_sat(longint v, bit m);
        longint r;
        if (!m) begin
            if (v > 64'sd2147483647) return 32'h7fffffff;
            if (v < -64'sd2147483648) return 32'h80000000;
            return int'(v);
        end
        r = (v + 32768) >>> 16;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%08h) expected %0d (0x%08h) at cycle %0d",
                     tag, act, act, exp, exp, cyc);
        end
    endtask

    // Cycle-by-cycle comparison against the scheduled expectations (R5)
    always @(negedge clk) begin
        if (running) begin
            if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
                check(res_valid == 1'b1, "R5 valid", int'(res_valid), 1);
                check(res_lane == q_lane[0], "R5 lane", int'(res_lane), int'(q_lane[0]));
                check(res == q_val[0], q_tag[0], int'(res), q_val[0]);
                void'(q_cyc.pop_front());
                void'(q_lane.pop_front());
                void'(q_val.pop_front());
                void'(q_tag.pop_front());
            end else begin
                check(res_valid == 1'b0, "R5 valid idle", int'(res_valid), 0);
            end
        end
    end

    // One job: priming beat, taps, optional bubbles and a busy start (R2, R3, R4, R8, R10)
    task automatic run_job(int taps, bit mode, bit gaps, string tag);
        longint a0 = 0;
        longint a1 = 0;
        for (int k = 0; k < taps; k++) begin
            a0 += longint'(c_a[k]) * longint'(s_a[k]);
            a1 += longint'(c_a[k]) * longint'(s_a[k+1]);
        end
        @(negedge clk);
        start = 1'b1; tap_count = 8'(taps); sat_mode = mode;
        @(negedge clk);
        start = 1'b0; sat_mode = ~mode;            // R10: later mode change ignored
        in_valid = 1'b1; samp = 16'(s_a[0]);
        coef = 16'h7fff;                          // R2: priming coefficient ignored
        @(negedge clk);
        for (int k = 0; k < taps; k++) begin
            if (gaps && (k % 3 == 1)) begin       // R4: bubble with junk data
                in_valid = 1'b0; coef = 16'h8000; samp = 16'h8000;
                @(negedge clk);
            end
            in_valid = 1'b1; coef = 16'(c_a[k]); samp = 16'(s_a[k+1]);
            if (k == 1) begin                     // R8: start while busy
                start = 1'b1; tap_count = 8'd3;
            end
            if (k == taps - 1) begin
                q_cyc.push_back(cyc + 3); q_lane.push_back(1'b0);
                q_val.push_back(ref_sat(a0, mode)); q_tag.push_back({tag, " lane0"});
                q_cyc.push_back(cyc + 4); q_lane.push_back(1'b1);
                q_val.push_back(ref_sat(a1, mode)); q_tag.push_back({tag, " lane1"});
            end
            @(negedge clk);
            start = 1'b0;
        end
        in_valid = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic fill_rand(int taps);
        for (int k = 0; k <= taps; k++) begin
            s_a[k] = int'($signed(16'($urandom)));
            if (k < taps) c_a[k] = int'($signed(16'($urandom)));
        end
    endtask

    task automatic fill_const(int taps, int cv, int sv);
        for (int k = 0; k <= taps; k++) begin
            s_a[k] = sv;
            if (k < taps) c_a[k] = cv;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(res_valid == 1'b0, "R1 valid", int'(res_valid), 0);
        check(res == 32'd0, "R1 result", int'(res), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_valid == 1'b0 && res == 32'd0, "R1 after release", int'(res), 0);
        running = 1'b1;

        fill_rand(5);   run_job(5, 1'b0, 1'b0, "R3 R2 basic");
        fill_rand(7);   run_job(7, 1'b0, 1'b1, "R4 R9 bubbles");
        fill_rand(1);   run_job(1, 1'b0, 1'b0, "R3 single tap");
        fill_const(4, 32767, 32767);   run_job(4, 1'b0, 1'b0, "R6 R11 positive clamp");
        fill_const(4, -32768, 32767);  run_job(4, 1'b0, 1'b0, "R6 negative clamp");

        c_a[0] = 1; c_a[1] = 1;
        s_a[0] = 16384; s_a[1] = 16384; s_a[2] = -32768;
        run_job(2, 1'b1, 1'b0, "R7 rounding");
        fill_const(4, -32768, -32768); run_job(4, 1'b1, 1'b0, "R7 clamp");
        fill_rand(9);   run_job(9, 1'b1, 1'b1, "R7 R10 random");

        // R8: zero tap count start, then a stray beat in idle (R4)
        @(negedge clk);
        start = 1'b1; tap_count = 8'd0;
        @(negedge clk);
        start = 1'b0; in_valid = 1'b1; coef = 16'd5; samp = 16'd5;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (8) @(negedge clk);

        for (int k = 0; k <= 255; k++) begin
            s_a[k] = (k % 2 == 0) ? -32768 : 32767;
            if (k < 255) c_a[k] = -32768;
        end
        run_job(255, 1'b1, 1'b0, "R11 long sum");
        fill_rand(3);   run_job(3, 1'b0, 1'b0, "R9 after long");

        check(q_cyc.size() == 0, "R5 all results seen", q_cyc.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule